// File: doc/BRIEF.md
# Four-Level Nesting Interrupt Arbiter

This block selects one interrupt to present to a processor core out of a wide set of request lines. Software gives each line a priority level through a small register bank. Each cycle the block looks at the levels the core's two-bit mask currently admits and picks the highest such level that has an active request. Within that level the lowest-numbered line wins. The choice is registered and sent to the core as a pending flag together with a vector address. The vector address is a software-set base with the winning line number appended below it, so every line gets its own table slot.

A mask value of m admits every level numbered m or higher. A handler that raises the mask to its own level therefore lets only higher levels in, and those can nest over it. A few low-numbered lines are hardwired to the top level, and every mask setting admits them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, pending is low, the vector address is zero, every programmable level field reads 00 and the vector base reads zero.
- R2: Each source has a 2-bit level field. Source i sits in register i/8 (addresses 0 to 10), bits [2*(i%8)+1 : 2*(i%8)]. Code 00 disables the source, 01 puts it at level 0, 10 at level 1 and 11 at level 2. Field bits for sources above 81 always read as zero.
- R3: Sources 0 and 1 are fixed at level 3, the top level. They are always enabled, ignore writes to their fields and read back as 11. Source 0 wins whenever it is asserted.
- R4: A level L is admitted only when L is greater than or equal to the core mask value (0 to 3). Mask 11 therefore admits only the fixed sources.
- R5: Among the admitted levels that have an active request, the highest level wins.
- R6: Within the winning level, the lowest-numbered active request wins.
- R7: The vector address is the 9-bit vector base in its upper bits with the 7-bit winning source number below it. The vector base register is at address 16 and keeps bits [8:0] of a write.
- R8: Pending and the vector address are registered. They follow a request change one clock later, and pending drops once no admitted request remains.
- R9: A request on a disabled source never raises pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register bus select |
| busWr | input | 1 | Register bus write enable |
| busAddr | input | 5 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational on address) |
| irq | input | 82 | Interrupt request lines, bit i is source i |
| coreMask | input | 2 | Core interrupt mask |
| pending | output | 1 | An admitted interrupt is waiting |
| vecAddr | output | 16 | Vector address {base, source number} |

## Verification
The bench builds the block with its default parameters: 82 sources, two fixed top-level sources and a 9-bit base in 16-bit registers. With these values the last level register is only partly filled, since it holds sources 80 and 81. The bench can therefore check that unused field bits read as zero and that the highest source number reaches the vector. These settings also let directed scenarios cover all four mask values against requests spread over every level, including the fixed ones.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LEVEL_CNT = 4;
  localparam int FIELD_W   = 2;

  typedef logic [FIELD_W-1:0] lvlField_t;

  // strobes from the bus decode to the datapath
  typedef struct packed {
    logic fieldWr;
    logic baseWr;
    logic fieldRd;
    logic baseRd;
  } regStrobe_t;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N     = 82,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    hit = |req;
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int NUM_REGS  = 11,
  parameter int BASE_ADDR = 16
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);
  logic inFields;
  logic inBase;

  always_comb begin
    inFields     = int'(busAddr) < NUM_REGS;
    inBase       = int'(busAddr) == BASE_ADDR;
    strb.fieldWr = busSel && busWr && inFields;
    strb.baseWr  = busSel && busWr && inBase;
    strb.fieldRd = busSel && !busWr && inFields;
    strb.baseRd  = busSel && !busWr && inBase;
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 82,
  parameter int NUM_FIXED = 2,
  parameter int DATA_W    = 16,
  parameter int BASE_W    = 9,
  parameter int ADDR_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  regStrobe_t                strb,
  input  logic [ADDR_W-1:0]         regIdx,
  input  logic [DATA_W-1:0]         busWdata,
  output logic [DATA_W-1:0]         busRdata,
  input  logic [NUM_SRC-1:0]        irq,
  input  logic [1:0]                coreMask,
  output logic                      pending,
  output logic [BASE_W+$clog2(NUM_SRC)-1:0] vecAddr
);
  localparam int SRC_PER_REG = DATA_W / FIELD_W;
  localparam int VEC_W       = $clog2(NUM_SRC);

  logic [NUM_SRC*FIELD_W-1:0] fieldVec;
  logic [NUM_SRC-1:0]         srcEn;
  logic [NUM_SRC*FIELD_W-1:0] srcLvl;
  logic [BASE_W-1:0]          vecBase;

  // per-source level storage; fixed sources are constants
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_FIXED) begin : g_fixed
      assign fieldVec[i*FIELD_W +: FIELD_W] = 2'b11;
      assign srcEn[i]                       = 1'b1;
      assign srcLvl[i*FIELD_W +: FIELD_W]   = 2'd3;
    end else begin : g_prog
      lvlField_t fieldQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fieldQ <= 2'b00;
        end else if (strb.fieldWr && int'(regIdx) == i / SRC_PER_REG) begin
          fieldQ <= busWdata[(i % SRC_PER_REG)*FIELD_W +: FIELD_W];
        end
      end
      assign fieldVec[i*FIELD_W +: FIELD_W] = fieldQ;
      assign srcEn[i]                       = fieldQ != 2'b00;
      assign srcLvl[i*FIELD_W +: FIELD_W]   = fieldQ - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           vecBase <= '0;
    else if (strb.baseWr) vecBase <= busWdata[BASE_W-1:0];
  end

  // one encoder per level
  logic [LEVEL_CNT-1:0] lvlHit;
  logic [VEC_W-1:0]     lvlIdx [LEVEL_CNT];

  for (genvar l = 0; l < LEVEL_CNT; l++) begin : g_lvl
    logic [NUM_SRC-1:0] lvlReq;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
      assign lvlReq[i] = irq[i] && srcEn[i] &&
                         (srcLvl[i*FIELD_W +: FIELD_W] == FIELD_W'(l));
    end
    irqc_prio_enc #(.N(NUM_SRC), .IDX_W(VEC_W)) u_enc (
      .req (lvlReq),
      .hit (lvlHit[l]),
      .idx (lvlIdx[l])
    );
  end

  logic             winValid;
  logic [VEC_W-1:0] winIdx;

  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    for (int l = 0; l < LEVEL_CNT; l++) begin
      if (lvlHit[l] && (l >= int'(coreMask))) begin
        winValid = 1'b1;
        winIdx   = lvlIdx[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      vecAddr <= '0;
    end else begin
      pending <= winValid;
      vecAddr <= winValid ? {vecBase, winIdx} : '0;
    end
  end

  // register readback
  logic [DATA_W-1:0] fieldRdData;
  always_comb begin
    fieldRdData = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(regIdx) == i / SRC_PER_REG)
        fieldRdData[(i % SRC_PER_REG)*FIELD_W +: FIELD_W] = fieldVec[i*FIELD_W +: FIELD_W];
    end
    if (strb.fieldRd)     busRdata = fieldRdData;
    else if (strb.baseRd) busRdata = DATA_W'(vecBase);
    else                  busRdata = '0;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 82,
  parameter int NUM_FIXED = 2,
  parameter int DATA_W    = 16,
  parameter int BASE_W    = 9,
  parameter int ADDR_W    = 5,
  parameter int BASE_ADDR = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              busSel,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [DATA_W-1:0]                 busWdata,
  output logic [DATA_W-1:0]                 busRdata,
  input  logic [NUM_SRC-1:0]                irq,
  input  logic [1:0]                        coreMask,
  output logic                              pending,
  output logic [BASE_W+$clog2(NUM_SRC)-1:0] vecAddr
);
  localparam int SRC_PER_REG = DATA_W / FIELD_W;
  localparam int NUM_REGS    = (NUM_SRC + SRC_PER_REG - 1) / SRC_PER_REG;

  regStrobe_t strb;

  irqc_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irqc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .DATA_W(DATA_W),
    .BASE_W(BASE_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .regIdx  (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irq     (irq),
    .coreMask(coreMask),
    .pending (pending),
    .vecAddr (vecAddr)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC   = 82,
  parameter int NUM_FIXED = 2,
  parameter int BASE_W    = 9
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_SRC-1:0]                irq,
  input logic [1:0]                        coreMask,
  input logic                              pending,
  input logic [BASE_W+$clog2(NUM_SRC)-1:0] vecAddr
);
  localparam int VEC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] irqPrev;
  logic [VEC_W-1:0]   vecIdx;
  assign vecIdx = vecAddr[VEC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqPrev <= '0;
    else        irqPrev <= irq;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !pending);

  assert_src0_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |=> (pending && vecIdx == '0));

  assert_top_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (coreMask == 2'b11 && irq[NUM_FIXED-1:0] == '0) |=> !pending);

  assert_winner_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && int'(vecIdx) < NUM_SRC) |-> irqPrev[vecIdx]);

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> int'(vecIdx) < NUM_SRC);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == '0) |=> !pending);
endmodule

bind irq_prio_ctrl irqc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .BASE_W(BASE_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .coreMask(coreMask),
  .pending (pending),
  .vecAddr (vecAddr)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [81:0] irq = '0;
  logic [1:0]  coreMask = 2'b00;
  logic        pending;
  logic [15:0] vecAddr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .coreMask(coreMask), .pending(pending), .vecAddr(vecAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  // drive requests and mask, then sample after the capturing edge
  task automatic applyReq(input logic [81:0] r, input logic [1:0] m);
    @(negedge clk);
    irq = r; coreMask = m;
    @(posedge clk); #1;
  endtask

  function automatic logic [81:0] bitOf(input int n);
    return 82'(1) << n;
  endfunction

  task automatic testReset();
    logic [15:0] d;
    chk("R1 pending after reset", 32'(pending), 0);
    chk("R1 vector after reset", 32'(vecAddr), 0);
    busRead(5'd5, d);  chk("R1 field reg 5 after reset", 32'(d), 0);
    busRead(5'd0, d);  chk("R3 fixed fields read 11", 32'(d), 32'h000F);
    busRead(5'd16, d); chk("R1 base after reset", 32'(d), 0);
  endtask

  task automatic testDisabled();
    applyReq(bitOf(40) | bitOf(60), 2'b00);
    applyReq(bitOf(40) | bitOf(60), 2'b00);
    chk("R9 disabled source not pending", 32'(pending), 0);
    applyReq('0, 2'b00);
  endtask

  task automatic testProgram();
    logic [15:0] d;
    busWrite(5'd10, 16'hFFFF);
    busRead(5'd10, d);  chk("R2 partial register tail reads zero", 32'(d), 32'h000F);
    busWrite(5'd10, 16'h000C);
    busWrite(5'd1, 16'h0020);
    busWrite(5'd2, 16'h0300);
    busWrite(5'd5, 16'h0001);
    busRead(5'd2, d);   chk("R2 field readback", 32'(d), 32'h0300);
    busWrite(5'd16, 16'hABCD);
    busRead(5'd16, d);  chk("R7 base keeps low 9 bits", 32'(d), 32'h01CD);
  endtask

  task automatic testLatency();
    @(negedge clk);
    irq = bitOf(40); coreMask = 2'b00;
    #1 chk("R8 no change before edge", 32'(pending), 0);
    @(posedge clk); #1;
    chk("R8 pending one clock later", 32'(pending), 1);
    chk("R7 vector for source 40", 32'(vecAddr), 32'hE6A8);
    applyReq(bitOf(40), 2'b01);
    chk("R4 level 0 blocked by mask 01", 32'(pending), 0);
    applyReq('0, 2'b00);
    chk("R8 pending drops when idle", 32'(pending), 0);
  endtask

  task automatic testLevels();
    applyReq(bitOf(40) | bitOf(10) | bitOf(81), 2'b00);
    chk("R5 highest level wins", 32'(vecAddr), 32'hE6D1);
    applyReq(bitOf(40) | bitOf(10) | bitOf(81) | bitOf(20), 2'b00);
    chk("R6 lowest index in level", 32'(vecAddr), 32'hE694);
    applyReq(bitOf(40) | bitOf(10) | bitOf(81) | bitOf(20), 2'b11);
    chk("R4 mask 11 blocks programmable", 32'(pending), 0);
    applyReq(bitOf(40) | bitOf(10), 2'b10);
    chk("R4 mask 10 blocks levels 0 and 1", 32'(pending), 0);
    applyReq(bitOf(40) | bitOf(10), 2'b01);
    chk("R4 mask 01 admits level 1", 32'(vecAddr), 32'hE68A);
    applyReq('0, 2'b00);
  endtask

  task automatic testFixed();
    logic [15:0] d;
    applyReq(bitOf(1) | bitOf(20), 2'b11);
    chk("R3 fixed source passes mask 11", 32'(vecAddr), 32'hE681);
    applyReq(bitOf(0) | bitOf(1) | bitOf(81), 2'b00);
    chk("R3 source 0 wins", 32'(vecAddr), 32'hE680);
    applyReq('0, 2'b00);
    busWrite(5'd0, 16'h0000);
    busRead(5'd0, d);  chk("R3 fixed field write ignored", 32'(d), 32'h000F);
    applyReq(bitOf(1), 2'b11);
    chk("R3 fixed source still enabled", 32'(pending), 1);
    applyReq('0, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    testReset();
    testDisabled();
    testProgram();
    testLatency();
    testLevels();
    testFixed();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule